// File: doc/BRIEF.md
# Masked Share Refresh and Compression Stage

This block sits at the end of one stage of a masked pipeline. The stage's combinational logic produces N shares of a W-bit secret. This unit adds fresh randomness to those shares, writes the result into the stage register, and can then fold the registered shares down to M output shares by XOR. The randomness is added before the register and the folding happens only after it. As a result, the register never holds a partial sum of shares that the following logic could combine with glitches.

Two refresh topologies are selected at elaboration time. In ring mode each share takes two neighbouring random words, so N random words are consumed. This mode suits designs that must also resist attacks at higher or multivariate order. In additive mode one random word fewer is consumed, and the last share absorbs the XOR of all the others. This mode is meant only for designs where first-order or univariate security is enough. The width of the random-word input follows the chosen mode. The unit does not compute the share terms and does not generate randomness.

Top module: `share_refresh_top`

## Requirements
- R1: When `en` is high at a rising clock edge, the refreshed and compressed value of the `shares_in` and `rand_in` present at that edge appears on `shares_out` after that edge and stays there until the next capture.
- R2: When `en` is low at a rising edge (and `rst_n` is high), `shares_out` keeps its previous value whatever `shares_in` and `rand_in` carry.
- R3: When `rst_n` is low at a rising edge, the share register clears to zero and `shares_out` reads zero after that edge, whatever `en` is. Reset takes priority over `en`.
- R4: Ring mode takes N random words. Share k (bits [k*W +: W]) is XORed with random word k and random word (k+1) mod N. Random word k is at bits [k*W +: W] of `rand_in`.
- R5: Additive mode takes N-1 random words. Shares 0 to N-2 are each XORed with their own random word k. Share N-1 is XORed with the XOR of all N-1 random words.
- R6: Output share j (bits [j*W +: W]) is the XOR of the registered shares j*G to j*G+G-1, where G = N/M. When M = N, every registered share is output unchanged.
- R7: In both modes, the XOR of all output shares equals the XOR of all input shares captured at the same edge, for any random input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Capture enable for the share register |
| shares_in | input | N*W | Unregistered share terms; share k at [k*W +: W] |
| rand_in | input | N*W (ring) or (N-1)*W (additive) | Fresh random words; word k at [k*W +: W] |
| shares_out | output | M*W | Registered, compressed shares; share j at [j*W +: W] |

## Verification
The bench drives three copies of the unit side by side: ring mode folded to two shares, additive mode folded to two shares, and ring mode without compression. The uncompressed copy shows each masked share on its own. If a ring that wraps the wrong neighbour, or a last-share sum that leaves out a word, only broke the per-share masks, the secret itself would still come out intact; this copy exposes that error. Random words are chosen so that each word has a distinct bit pattern. A design that paired the wrong words, or that compressed before masking, would then produce outputs that no correct pairing gives. Hold cycles with changing inputs catch a register that ignores `en`. A reset asserted together with `en` catches a reset that does not take priority.

// File: rtl/share_refresh_pkg.sv
// Shared types for the share refresh stage.
// Assumes: nothing beyond IEEE 1800-2017.
package share_refresh_pkg;
    // Refresh topology chosen at elaboration time.
    typedef enum logic {
        RFR_RING     = 1'b0,  // N random words, each shared by two neighbouring shares
        RFR_ADDITIVE = 1'b1   // N-1 random words, the last share takes their XOR
    } refresh_mode_e;
endpackage

// File: rtl/share_mask_gen.sv
// Builds one mask word per share from the fresh random words.
// Ring: mask k = r[k] ^ r[(k+1) mod N]. Additive: mask k = r[k] for
// k < N-1, and mask N-1 = XOR of all N-1 words.
// Assumes N >= 2 and a random bus of the width the mode requires.
module share_mask_gen
    import share_refresh_pkg::*;
#(
    parameter int            N    = 4,
    parameter int            W    = 8,
    parameter refresh_mode_e MODE = RFR_RING,
    parameter int            RW   = N * W
) (
    input  logic [RW-1:0]  rand_in,
    output logic [N*W-1:0] mask
);
    if (MODE == RFR_RING) begin : g_ring
        for (genvar k = 0; k < N; k++) begin : g_word
            localparam int NEXT = (k + 1) % N;
            assign mask[k*W +: W] = rand_in[k*W +: W] ^ rand_in[NEXT*W +: W];
        end
    end else begin : g_additive
        logic [W-1:0] sum;

        for (genvar k = 0; k < N - 1; k++) begin : g_word
            assign mask[k*W +: W] = rand_in[k*W +: W];
        end

        // Fold all random words into the last share's mask.
        always_comb begin
            sum = '0;
            for (int k = 0; k < N - 1; k++) sum ^= rand_in[k*W +: W];
        end

        assign mask[(N-1)*W +: W] = sum;
    end
endmodule

// File: rtl/share_bank.sv
// Stage register for N shares. Each share is XORed with its mask before
// the register, so only refreshed shares are ever stored.
// Assumes a synchronous active-low reset that takes priority over enable.
module share_bank #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [N*W-1:0] shares_in,
    input  logic [N*W-1:0] mask,
    output logic [N*W-1:0] q
);
    for (genvar k = 0; k < N; k++) begin : g_share
        // Capture one refreshed share, clear on reset, hold when idle.
        always_ff @(posedge clk) begin
            if (!rst_n)  q[k*W +: W] <= '0;
            else if (en) q[k*W +: W] <= shares_in[k*W +: W] ^ mask[k*W +: W];
        end
    end
endmodule

// File: rtl/share_compress.sv
// Folds N registered shares into M outputs. Output j is the XOR of the
// G = N/M consecutive shares j*G to j*G+G-1.
// Assumes M divides N. With M = N the outputs are plain wires.
module share_compress #(
    parameter int N = 4,
    parameter int W = 8,
    parameter int M = 2
) (
    input  logic [N*W-1:0] shares,
    output logic [M*W-1:0] folded
);
    localparam int G = N / M;

    for (genvar j = 0; j < M; j++) begin : g_out
        if (G == 1) begin : g_pass
            assign folded[j*W +: W] = shares[j*W +: W];
        end else begin : g_fold
            logic [W-1:0] acc;

            // XOR one group of consecutive shares.
            always_comb begin
                acc = '0;
                for (int i = 0; i < G; i++) acc ^= shares[(j*G + i)*W +: W];
            end

            assign folded[j*W +: W] = acc;
        end
    end
endmodule

// File: rtl/share_refresh_top.sv
// Share refresh and compression stage: mask generation, then the refreshed
// stage register, then XOR compression down to M shares after the register.
// Assumes N >= 2, M divides N, and rand_in carries fresh uniform words on
// every enabled cycle.
module share_refresh_top
    import share_refresh_pkg::*;
#(
    parameter int            N    = 4,
    parameter int            W    = 8,
    parameter int            M    = 2,
    parameter refresh_mode_e MODE = RFR_RING,
    localparam int           RW   = ((MODE == RFR_RING) ? N : N - 1) * W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [N*W-1:0] shares_in,
    input  logic [RW-1:0]  rand_in,
    output logic [M*W-1:0] shares_out
);
    logic [N*W-1:0] mask;
    logic [N*W-1:0] held;

    share_mask_gen #(.N(N), .W(W), .MODE(MODE), .RW(RW)) u_mask (
        .rand_in (rand_in),
        .mask    (mask)
    );

    share_bank #(.N(N), .W(W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .shares_in (shares_in),
        .mask      (mask),
        .q         (held)
    );

    share_compress #(.N(N), .W(W), .M(M)) u_fold (
        .shares (held),
        .folded (shares_out)
    );
endmodule

// File: rtl/share_refresh_chk.sv
// Checker for share_refresh_top, attached by bind. It watches only the
// top-level ports and keeps its own reference of the secret and the masks.
module share_refresh_chk
    import share_refresh_pkg::*;
#(
    parameter int            N    = 4,
    parameter int            W    = 8,
    parameter int            M    = 2,
    parameter refresh_mode_e MODE = RFR_RING,
    parameter int            RW   = N * W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en,
    input logic [N*W-1:0] shares_in,
    input logic [RW-1:0]  rand_in,
    input logic [M*W-1:0] shares_out
);
    logic [W-1:0]   secret_in;
    logic [W-1:0]   secret_out;
    logic [N*W-1:0] ref_shares;
    logic [W-1:0]   rsum;

    // Unmask the inputs and the outputs, and build a per-share reference.
    always_comb begin
        secret_in  = '0;
        secret_out = '0;
        rsum       = '0;
        for (int k = 0; k < N; k++) secret_in ^= shares_in[k*W +: W];
        for (int j = 0; j < M; j++) secret_out ^= shares_out[j*W +: W];
        for (int k = 0; k < RW / W; k++) rsum ^= rand_in[k*W +: W];
        for (int k = 0; k < N; k++) begin
            if (MODE == RFR_RING)
                ref_shares[k*W +: W] = shares_in[k*W +: W] ^ rand_in[k*W +: W]
                                     ^ rand_in[((k + 1) % N)*W +: W];
            else if (k < N - 1)
                ref_shares[k*W +: W] = shares_in[k*W +: W] ^ rand_in[k*W +: W];
            else
                ref_shares[k*W +: W] = shares_in[k*W +: W] ^ rsum;
        end
    end

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(shares_out));

    a_r3_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (shares_out == '0));

    a_r7_secret_kept: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (secret_out == $past(secret_in)));

    a_r1_capture_secret: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(rst_n)) |=> (secret_out != $past(secret_out)) || (secret_out == $past(secret_in)));

    if (M == N) begin : g_uncompressed
        if (MODE == RFR_RING) begin : g_ring
            a_r4_ring_masks: assert property (@(posedge clk) disable iff (!rst_n)
                en |=> (shares_out == $past(ref_shares)));
        end else begin : g_add
            a_r5_additive_masks: assert property (@(posedge clk) disable iff (!rst_n)
                en |=> (shares_out == $past(ref_shares)));
        end
    end
endmodule

bind share_refresh_top share_refresh_chk #(
    .N(N), .W(W), .M(M), .MODE(MODE), .RW(RW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .shares_in  (shares_in),
    .rand_in    (rand_in),
    .shares_out (shares_out)
);

// File: tb/share_refresh_top_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results per cycle, the
// monitor pops and compares them one step after each rising edge.
module share_refresh_top_test;
    import share_refresh_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] shares_in = '0;
    logic [31:0] rand_in = '0;
    logic [15:0] out_ring, out_add;
    logic [31:0] out_full;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] q_ring[$];
    logic [15:0] q_add[$];
    logic [31:0] q_full[$];
    logic [7:0]  q_sec[$];
    string       q_tag[$];

    logic [15:0] last_ring = '0, last_add = '0;
    logic [31:0] last_full = '0;
    logic [7:0]  last_sec = '0;

    always #2.5 clk = ~clk;

    share_refresh_top #(.N(4), .W(8), .M(2), .MODE(RFR_RING)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .shares_in(shares_in),
        .rand_in(rand_in), .shares_out(out_ring));

    share_refresh_top #(.N(4), .W(8), .M(2), .MODE(RFR_ADDITIVE)) uut_add (
        .clk(clk), .rst_n(rst_n), .en(en), .shares_in(shares_in),
        .rand_in(rand_in[23:0]), .shares_out(out_add));

    share_refresh_top #(.N(4), .W(8), .M(4), .MODE(RFR_RING)) uut_full (
        .clk(clk), .rst_n(rst_n), .en(en), .shares_in(shares_in),
        .rand_in(rand_in), .shares_out(out_full));

    // Ring reference for R4: share k takes words k and (k+1) mod 4.
    function automatic logic [31:0] ring_ref(logic [31:0] s, logic [31:0] r);
        logic [31:0] o;
        for (int k = 0; k < 4; k++)
            o[k*8 +: 8] = s[k*8 +: 8] ^ r[k*8 +: 8] ^ r[((k + 1) % 4)*8 +: 8];
        return o;
    endfunction

    // Additive reference for R5: the last share takes r0^r1^r2.
    function automatic logic [31:0] add_ref(logic [31:0] s, logic [23:0] r);
        logic [31:0] o;
        o[7:0]   = s[7:0]   ^ r[7:0];
        o[15:8]  = s[15:8]  ^ r[15:8];
        o[23:16] = s[23:16] ^ r[23:16];
        o[31:24] = s[31:24] ^ r[7:0] ^ r[15:8] ^ r[23:16];
        return o;
    endfunction

    // Compression for R6 with G = 2: out0 = s0^s1, out1 = s2^s3.
    function automatic logic [15:0] fold2(logic [31:0] v);
        return {v[31:24] ^ v[23:16], v[15:8] ^ v[7:0]};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle and queue the result expected after the next edge.
    task automatic apply(bit r_n, bit e, logic [31:0] s, logic [31:0] r, string tag);
        @(negedge clk);
        rst_n = r_n; en = e; shares_in = s; rand_in = r;
        if (!r_n) begin
            last_ring = '0; last_add = '0; last_full = '0; last_sec = '0;
        end else if (e) begin
            last_full = ring_ref(s, r);
            last_ring = fold2(last_full);
            last_add  = fold2(add_ref(s, r[23:0]));
            last_sec  = s[7:0] ^ s[15:8] ^ s[23:16] ^ s[31:24];
        end
        q_ring.push_back(last_ring);
        q_add.push_back(last_add);
        q_full.push_back(last_full);
        q_sec.push_back(last_sec);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_tag.size() != 0) begin
                string t;
                logic [15:0] er, ea;
                logic [31:0] ef;
                logic [7:0]  es;
                t = q_tag.pop_front();
                er = q_ring.pop_front();
                ea = q_add.pop_front();
                ef = q_full.pop_front();
                es = q_sec.pop_front();
                check({t, " ring/2 (R4 R6)"}, {16'h0, out_ring}, {16'h0, er});
                check({t, " additive/2 (R5 R6)"}, {16'h0, out_add}, {16'h0, ea});
                check({t, " ring/4 (R4 R6)"}, out_full, ef);
                check({t, " secret (R7)"}, {24'h0, out_ring[7:0] ^ out_ring[15:8]}, {24'h0, es});
                check({t, " secret additive (R7)"}, {24'h0, out_add[7:0] ^ out_add[15:8]}, {24'h0, es});
            end
        end
    end

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        apply(1'b0, 1'b0, 32'hDEADBEEF, 32'h12345678, "R3 reset state");
        apply(1'b0, 1'b1, 32'hDEADBEEF, 32'h12345678, "R3 reset with enable");
        apply(1'b1, 1'b1, 32'h44332211, 32'h00000000, "R1 R6 zero random");
        apply(1'b1, 1'b1, 32'h00000000, 32'h08040201, "R4 R5 single-bit words");
        apply(1'b1, 1'b1, 32'hA5C3F00F, 32'h80402010, "R1 R4 R5 pattern B");
        apply(1'b1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R2 hold ones");
        apply(1'b1, 1'b0, 32'h13579BDF, 32'h2468ACE0, "R2 hold mixed");
        apply(1'b1, 1'b1, 32'h0F0F0F0F, 32'hF0E0C080, "R1 R7 pattern C");
        apply(1'b1, 1'b1, 32'h01000000, 32'hFF000000, "R4 wrap word");
        apply(1'b0, 1'b1, 32'h5A5A5A5A, 32'h33333333, "R3 mid-run reset");
        apply(1'b1, 1'b0, 32'h77777777, 32'h11111111, "R2 hold after reset");
        for (int i = 0; i < 24; i++)
            apply(1'b1, (i % 3) != 0, 32'h9E3779B9 * (i + 1), 32'h7F4A7C15 * (i + 3), "R1 R2 R7 sweep");
        while (q_tag.size() != 0) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule